// File: doc/BRIEF.md
# Slave Address Matcher

This block decides whether an I2C target has been addressed. After each START or repeated START it examines the first received byte only. It compares that byte with a stored 8-bit own-address value and updates an addressed flag. It also records the transfer-direction bit carried in bit 0 of that byte. Bus shifting, acknowledge generation and the check of the second address byte in 10-bit mode sit outside the block. That second-byte check is done by software.

A single mode input picks one of two comparisons. In 7-bit mode, bits 7..1 of the received byte must equal bits 7..1 of the own address, and bit 0 plays no part. In 10-bit mode, all eight bits must agree, bit 0 included. Software uses this as follows. Once it has verified both bytes of a 10-bit address, it sets own-address bit 0 to 1. A later repeated START that carries the first address byte with the read bit then matches again in hardware.

Top module: `slave_addr_matcher`

## Requirements
- R1: After reset, `addressed` and `rwBit` are both 0, and no byte is evaluated until a START or repeated START has been seen.
- R2: With `tenBitMode` = 0, an evaluated byte whose bits 7..1 equal `ownAddr[7:1]` sets `addressed` to 1 on the clock edge that accepts the byte.
- R3: With `tenBitMode` = 0, bit 0 of the byte and `ownAddr[0]` are ignored: both R/W values match the same address.
- R4: With `tenBitMode` = 1, `addressed` becomes 1 only if all eight bits of the byte equal `ownAddr`, bit 0 included.
- R5: An evaluated byte that does not match sets `addressed` to 0, even if it was 1 before.
- R6: An evaluated byte's bit 0 appears on `rwBit` on the same edge that updates `addressed`. `rwBit` changes at no other time.
- R7: Only the first byte with `rxValid` = 1 after a START or repeated START is evaluated. Later bytes leave both outputs unchanged.
- R8: A cycle with `stopSeen` = 1 clears `addressed` on that edge, and no byte is evaluated after it until the next START or repeated START.
- R9: A byte presented in the same cycle as a START, repeated START or STOP indication is ignored. A START or repeated START alone does not change either output.
- R10: In 10-bit mode with `ownAddr[0]` = 1, a repeated START followed by `ownAddr` leaves `addressed` at 1 and `rwBit` at 1. With `ownAddr[0]` = 0, the same byte clears `addressed`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxByte | input | BYTE_W | Received byte, MSB first on the wire; bit 0 is R/W |
| rxValid | input | 1 | One-cycle strobe: `rxByte` holds a complete byte |
| startSeen | input | 1 | One-cycle strobe: START condition detected |
| reStartSeen | input | 1 | One-cycle strobe: repeated START detected |
| stopSeen | input | 1 | One-cycle strobe: STOP condition detected |
| ownAddr | input | BYTE_W | Stored own address; bit 0 is the stored direction bit |
| tenBitMode | input | 1 | 0: 7-bit comparison, 1: full 8-bit first-byte comparison |
| addressed | output | 1 | Registered addressed-as-slave flag |
| rwBit | output | 1 | Registered bit 0 of the last evaluated byte |

## Verification
The bench builds the block with its default byte width of 8, the width every I2C address byte has. With that width it can use every own-address value. About half the random bytes are forced to share the upper seven bits with the own address, so both the match path and the mismatch path are exercised often in each mode. The indication strobes are mixed at random and sometimes arrive in the same cycle as a byte, which exercises the ordering of START, STOP and byte strobes. Directed sequences cover the 10-bit repeated-START read, where own-address bit 0 is rewritten between bytes.

// File: rtl/sam_pkg.sv
package sam_pkg;

  // Strobes from the sequencing control to the compare datapath.
  typedef struct packed {
    logic evalByte;   // compare the present byte and capture R/W
    logic dropMatch;  // force the addressed flag low
  } ctrlStrobe_t;

endpackage

// File: rtl/sam_ctrl.sv
module sam_ctrl
  import sam_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxValid,
  input  logic        startSeen,
  input  logic        reStartSeen,
  input  logic        stopSeen,
  output ctrlStrobe_t strobes,
  output logic        armed
);

  logic armedQ;
  logic anyStart;
  logic evalNow;

  assign anyStart = startSeen | reStartSeen;
  // A byte counts only when armed and no bus condition shares its cycle.
  assign evalNow  = armedQ & rxValid & ~anyStart & ~stopSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armedQ <= 1'b0;
    end else if (anyStart) begin
      armedQ <= 1'b1;
    end else if (stopSeen || evalNow) begin
      armedQ <= 1'b0;
    end
  end

  always_comb begin
    strobes           = '0;
    strobes.evalByte  = evalNow;
    strobes.dropMatch = stopSeen;
  end

  assign armed = armedQ;

endmodule

// File: rtl/sam_datapath.sv
module sam_datapath
  import sam_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic [BYTE_W-1:0] ownAddr,
  input  logic              tenBitMode,
  input  ctrlStrobe_t       strobes,
  output logic              addressed,
  output logic              rwBit
);

  localparam int DIR_POS = 0;

  logic [BYTE_W-1:0] careMask;
  logic [BYTE_W-1:0] bitDiff;
  logic              byteMatch;

  // Per-bit masked compare; the direction bit only counts in 10-bit mode.
  for (genvar i = 0; i < BYTE_W; i++) begin : g_cmp
    if (i == DIR_POS) begin : g_dir
      assign careMask[i] = tenBitMode;
    end else begin : g_addr
      assign careMask[i] = 1'b1;
    end
    assign bitDiff[i] = (rxByte[i] ^ ownAddr[i]) & careMask[i];
  end

  assign byteMatch = ~|bitDiff;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addressed <= 1'b0;
      rwBit     <= 1'b0;
    end else begin
      if (strobes.dropMatch) begin
        addressed <= 1'b0;
      end else if (strobes.evalByte) begin
        addressed <= byteMatch;
      end
      if (strobes.evalByte) begin
        rwBit <= rxByte[DIR_POS];
      end
    end
  end

endmodule

// File: rtl/slave_addr_matcher.sv
module slave_addr_matcher
  import sam_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              rxValid,
  input  logic              startSeen,
  input  logic              reStartSeen,
  input  logic              stopSeen,
  input  logic [BYTE_W-1:0] ownAddr,
  input  logic              tenBitMode,
  output logic              addressed,
  output logic              rwBit
);

  ctrlStrobe_t strobes;
  logic        armedNow;

  sam_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .rxValid     (rxValid),
    .startSeen   (startSeen),
    .reStartSeen (reStartSeen),
    .stopSeen    (stopSeen),
    .strobes     (strobes),
    .armed       (armedNow)
  );

  sam_datapath #(.BYTE_W(BYTE_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .rxByte     (rxByte),
    .ownAddr    (ownAddr),
    .tenBitMode (tenBitMode),
    .strobes    (strobes),
    .addressed  (addressed),
    .rwBit      (rwBit)
  );

endmodule

// File: rtl/sam_checker.sv
module sam_checker #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [BYTE_W-1:0] rxByte,
  input logic              rxValid,
  input logic              startSeen,
  input logic              reStartSeen,
  input logic              stopSeen,
  input logic [BYTE_W-1:0] ownAddr,
  input logic              tenBitMode,
  input logic              addressed,
  input logic              rwBit,
  input logic              armed
);

  logic quiet;
  logic evalCyc;
  assign quiet   = ~startSeen & ~reStartSeen & ~stopSeen;
  assign evalCyc = armed & rxValid & quiet;

  // R2 / R3: 7-bit upper-field match sets the flag whatever bit 0 is
  p_match7_r2: assert property (@(posedge clk) disable iff (!rstN)
    evalCyc && !tenBitMode && (rxByte[BYTE_W-1:1] == ownAddr[BYTE_W-1:1]) |=> addressed);

  // R4: 10-bit mode needs every bit equal
  p_match10_r4: assert property (@(posedge clk) disable iff (!rstN)
    evalCyc && tenBitMode |=> (addressed == ($past(rxByte) == $past(ownAddr))));

  // R5: upper-field mismatch clears the flag
  p_mismatch_r5: assert property (@(posedge clk) disable iff (!rstN)
    evalCyc && (rxByte[BYTE_W-1:1] != ownAddr[BYTE_W-1:1]) |=> !addressed);

  // R6: direction bit captured from bit 0
  p_rw_capture_r6: assert property (@(posedge clk) disable iff (!rstN)
    evalCyc |=> (rwBit == $past(rxByte[0])));

  // R7 / R9: without evaluation and without STOP, outputs hold
  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !evalCyc && !stopSeen |=> $stable(addressed) && $stable(rwBit));

  // R8: STOP clears the flag and disarms
  p_stop_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen |=> !addressed);
  p_stop_disarms_r8: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen && !startSeen && !reStartSeen |=> !armed);

endmodule

bind slave_addr_matcher sam_checker #(.BYTE_W(BYTE_W)) i_chk (
  .clk         (clk),
  .rstN        (rstN),
  .rxByte      (rxByte),
  .rxValid     (rxValid),
  .startSeen   (startSeen),
  .reStartSeen (reStartSeen),
  .stopSeen    (stopSeen),
  .ownAddr     (ownAddr),
  .tenBitMode  (tenBitMode),
  .addressed   (addressed),
  .rwBit       (rwBit),
  .armed       (armedNow)
);

// File: tb/test_slave_addr_matcher.sv
`timescale 1ns/1ps
module test_slave_addr_matcher;

  localparam int BW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [BW-1:0] rxByte = '0;
  logic          rxValid = 1'b0;
  logic          startSeen = 1'b0;
  logic          reStartSeen = 1'b0;
  logic          stopSeen = 1'b0;
  logic [BW-1:0] ownAddr = 8'hA4;
  logic          tenBitMode = 1'b0;
  logic          addressed;
  logic          rwBit;

  int checks = 0;
  int errors = 0;
  bit mAddr = 0, mRw = 0, mArmed = 0;

  always #2 clk = ~clk;

  slave_addr_matcher #(.BYTE_W(BW)) i_slave_addr_matcher (
    .clk(clk), .rstN(rstN), .rxByte(rxByte), .rxValid(rxValid),
    .startSeen(startSeen), .reStartSeen(reStartSeen), .stopSeen(stopSeen),
    .ownAddr(ownAddr), .tenBitMode(tenBitMode),
    .addressed(addressed), .rwBit(rwBit)
  );

  function automatic bit expMatch(logic [BW-1:0] b, logic [BW-1:0] a, logic tb);
    if (tb) return b == a;
    return b[BW-1:1] == a[BW-1:1];
  endfunction

  task automatic check(string tag, logic actA, logic expA, logic actR, logic expR);
    checks++;
    if (actA !== expA || actR !== expR) begin
      errors++;
      $display("FAIL %s addressed=%0b exp=%0b rwBit=%0b exp=%0b", tag, actA, expA, actR, expR);
    end
  endtask

  // One cycle of stimulus, model update, and output check after the edge.
  task automatic step(string tag, bit st, bit rs, bit sp, bit v, logic [BW-1:0] b);
    startSeen = st; reStartSeen = rs; stopSeen = sp; rxValid = v; rxByte = b;
    if (v && !st && !rs && !sp && mArmed) begin
      mAddr = expMatch(b, ownAddr, tenBitMode);
      mRw = b[0];
      mArmed = 0;
    end
    if (sp) begin mAddr = 0; mArmed = 0; end
    if (st || rs) mArmed = 1;
    @(negedge clk);
    startSeen = 0; reStartSeen = 0; stopSeen = 0; rxValid = 0;
    check(tag, addressed, mAddr, rwBit, mRw);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog addressed=%0b exp=done rwBit=%0b exp=done", addressed, rwBit);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk); @(negedge clk);
    check("R1 reset", addressed, 1'b0, rwBit, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    // R1: byte with no prior START ignored
    step("R1 unarmed byte", 0, 0, 0, 1, 8'hA4);
    // R2 / R3: 7-bit match with write and read
    step("R2 start", 1, 0, 0, 0, 8'h00);
    step("R2 write match", 0, 0, 0, 1, 8'hA4);
    step("R3 restart", 0, 1, 0, 0, 8'h00);
    step("R3 read match", 0, 0, 0, 1, 8'hA5);
    // R7: later data byte does not change the flag
    step("R7 data byte", 0, 0, 0, 1, 8'h13);
    // R5: mismatch clears
    step("R5 start", 1, 0, 0, 0, 8'h00);
    step("R5 mismatch", 0, 0, 0, 1, 8'h25);
    // R8: STOP clears and disarms
    step("R8 start", 1, 0, 0, 0, 8'h00);
    step("R8 match", 0, 0, 0, 1, 8'hA4);
    step("R8 stop", 0, 0, 1, 0, 8'h00);
    step("R8 byte after stop", 0, 0, 0, 1, 8'hA5);
    // R9: byte in START cycle ignored; START leaves outputs alone
    step("R9 start+byte", 1, 0, 0, 1, 8'hA5);
    step("R9 first byte", 0, 0, 0, 1, 8'hA5);
    step("R9 stop+byte", 0, 0, 1, 1, 8'hA4);
    // R4: 10-bit first byte, stored bit 0 = 0
    tenBitMode = 1'b1; ownAddr = 8'hF2;
    step("R4 start", 1, 0, 0, 0, 8'h00);
    step("R4 bit0 differs", 0, 0, 0, 1, 8'hF3);
    step("R4 start", 1, 0, 0, 0, 8'h00);
    step("R4 full match", 0, 0, 0, 1, 8'hF2);
    step("R4 second byte", 0, 0, 0, 1, 8'h5C);
    // R10: software sets stored bit 0, then repeated START read
    ownAddr = 8'hF3;
    step("R10 restart", 0, 1, 0, 0, 8'h00);
    step("R10 read match", 0, 0, 0, 1, 8'hF3);
    ownAddr = 8'hF2;
    step("R10 restart", 0, 1, 0, 0, 8'h00);
    step("R10 read no match", 0, 0, 0, 1, 8'hF3);
    step("R10 stop", 0, 0, 1, 0, 8'h00);

    // Random mix: R2..R9
    for (int i = 0; i < 3000; i++) begin
      int act;
      logic [BW-1:0] b;
      act = $urandom_range(0, 9);
      b = BW'($urandom);
      if ($urandom_range(0, 1) == 1) b[BW-1:1] = ownAddr[BW-1:1];
      if (act == 9) begin
        tenBitMode = $urandom_range(0, 1) == 1;
        ownAddr = BW'($urandom);
        continue;
      end
      step(tenBitMode ? "R4 random" : "R2 random",
           act == 0 || act == 7, act == 1, act == 2 || act == 8,
           act >= 3 && act <= 8, b);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule